// File: doc/BRIEF.md
# Pipelined Multi-Channel Ready/Valid Link

This block carries flits for several virtual channels over one point-to-point link whose forward and return paths are built from plain registers with no stall capability. Each channel keeps its own handshake. A sender-side round-robin arbiter puts at most one flit per cycle onto the forward path. That flit travels with its channel number through `LF` register stages. On the receive side it lands in a FIFO owned by that channel. Each FIFO drives a ready bit from its free space, and the ready vector travels back to the sender through `LB` register stages.

A flit cannot be held once it enters the link. Because of this, a receiver FIFO keeps its ready high only while it can still absorb every flit that the round trip may yet deliver. The ready is computed as free slots after the write of the current cycle, compared against `LF+LB`. When a ready falls, the FIFO still has at least `LF+LB-1` free slots. A stall on one channel never blocks traffic on any other channel. Each channel offers its own pop port, and flits leave that port in the order they were sent.

Top module: `vcl_pipe_link`

## Requirements
- R1: While reset is asserted, and until the first ready vector has crossed the return path, `snk_valid` and `src_ready` are all zero.
- R2: Every flit accepted on source channel v (`src_valid[v]` and `src_ready[v]` high in the same cycle) leaves on sink channel v exactly once. Its data is unchanged, and flits of one channel leave in the order they were accepted.
- R3: At most one bit of `src_ready` is high in any cycle, and `src_ready[v]` is high only when `src_valid[v]` is high.
- R4: No receiver FIFO ever overflows. Take a channel whose sink is stalled, starting from an empty buffer and an idle link, with a source that offers a flit every cycle. That channel accepts exactly `DEPTH` flits and then accepts no more until the sink drains. All of those flits are delivered once the sink is released.
- R5: While one channel's sink is stalled, another channel whose sink is always ready keeps accepting a flit every cycle once the stalled channel has stopped.
- R6: On an idle link with empty buffers, a flit accepted in cycle c shows `snk_valid` high on its channel in cycle c+LF+1.
- R7: When all channels offer flits continuously and all sinks are ready, accepted channel numbers follow the order 0,1,...,NVC-1,0,... with no channel skipped.
- R8: With `DEPTH >= LF+LB+2`, a single channel whose sink is always ready accepts one flit every cycle in steady state.
- R9: While `snk_valid[v]` is high and `snk_ready[v]` is low, `snk_valid[v]` stays high and the data in `snk_data[v*DW +: DW]` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_valid | input | NVC | Per-channel flit offered by the source |
| src_data | input | NVC*DW | Per-channel flit data; channel v uses bits v*DW +: DW |
| src_ready | output | NVC | Per-channel accept; high for the granted channel in the cycle its flit enters the link |
| snk_valid | output | NVC | Per-channel flit available at the receiver FIFO head |
| snk_data | output | NVC*DW | Per-channel head data; channel v uses bits v*DW +: DW |
| snk_ready | input | NVC | Per-channel consume strobe from the sink |

## Verification
The sharpest corner is the fill of a stalled channel. The bench counts accepted flits and expects exactly `DEPTH`. A threshold that ignores the current write, or that is off by one stage of round trip, either drops flits into a full FIFO (the scoreboard then reports missing data) or stops short and leaves capacity unused. Isolation is checked by stalling one sink while a neighbour runs. A design that shares a ready or lets a blocked channel hold the arbiter would starve that neighbour. Random stalls on every sink and source expose a sender that sends without an observed ready, which shows up as duplicated or lost flits and as wrong per-channel order. Exact idle latency and strict rotation of grants catch extra pipeline stages and a faulty arbiter pointer.

// File: rtl/vcl_pkg.sv
package vcl_pkg;

  // Number of bits needed to name one of n channels (at least one bit).
  function automatic int vcl_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Free-slot level at which a receiver keeps its ready high.
  function automatic int vcl_keep_level(input int lf, input int lb);
    return lf + lb;
  endfunction

endpackage

// File: rtl/vcl_delay.sv
module vcl_delay #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb stg_d[i] = din;
    end else begin : g_body
      always_comb stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_d[i];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/vcl_sender.sv
module vcl_sender #(
  parameter int NVC = 3,
  parameter int DW  = 16,
  parameter int VW  = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NVC-1:0]    src_valid,
  input  logic [NVC*DW-1:0] src_data,
  input  logic [NVC-1:0]    seen_rdy,
  output logic [NVC-1:0]    src_ready,
  output logic              lnk_valid,
  output logic [VW-1:0]     lnk_vc,
  output logic [DW-1:0]     lnk_data
);

  logic [NVC-1:0] req;
  logic [VW-1:0]  ptr_q, ptr_d;
  logic           ptr_en;
  logic [VW-1:0]  win;
  logic           hit;

  assign req = src_valid & seen_rdy;

  // Round-robin search starting just after the last granted channel.
  always_comb begin
    win = ptr_q;
    hit = 1'b0;
    for (int off = 1; off <= NVC; off++) begin
      int cand;
      cand = int'(ptr_q) + off;
      if (cand >= NVC) cand = cand - NVC;
      if (!hit && req[cand[VW-1:0]]) begin
        hit = 1'b1;
        win = cand[VW-1:0];
      end
    end
  end

  always_comb begin
    src_ready = '0;
    if (hit) src_ready[win] = 1'b1;
  end

  assign lnk_valid = hit;
  assign lnk_vc    = win;
  assign lnk_data  = src_data[int'(win)*DW +: DW];

  assign ptr_en = hit;
  assign ptr_d  = win;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= VW'(NVC - 1);
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R3: one flit per cycle, only to a channel that offered one
  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(src_ready));
  assert_grant_valid_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (src_ready & ~src_valid) == '0);
  // R4: a flit enters the link only against an observed ready
  assert_send_seen_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    lnk_valid |-> seen_rdy[lnk_vc]);

endmodule

// File: rtl/vcl_vc_fifo.sv
module vcl_vc_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 7,
  parameter int KEEP  = 5
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  input  logic          pop_ready,
  output logic          rdy_out
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop;
  int            free_after;

  assign pop       = pop_valid && pop_ready;
  assign pop_valid = (cnt_q != '0);
  assign pop_data  = mem[rptr_q];

  // Free space after this cycle's arrival; pops are not credited.
  assign free_after = DEPTH - int'(cnt_q) - (wr_en ? 1 : 0);
  assign rdy_out    = (free_after >= KEEP);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_en) wptr_d = (int'(wptr_q) == DEPTH - 1) ? '0 : wptr_q + 1'b1;
    if (pop)   rptr_d = (int'(rptr_q) == DEPTH - 1) ? '0 : rptr_q + 1'b1;
    if (wr_en && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  // R4: the ready threshold leaves room for everything in flight
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> (int'(cnt_q) < DEPTH || pop));
  // R9: a waiting head flit is held
  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));

endmodule

// File: rtl/vcl_pipe_link.sv
module vcl_pipe_link
  import vcl_pkg::*;
#(
  parameter int NVC   = 3,
  parameter int DW    = 16,
  parameter int LF    = 3,
  parameter int LB    = 2,
  parameter int DEPTH = LF + LB + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NVC-1:0]    src_valid,
  input  logic [NVC*DW-1:0] src_data,
  output logic [NVC-1:0]    src_ready,
  output logic [NVC-1:0]    snk_valid,
  output logic [NVC*DW-1:0] snk_data,
  input  logic [NVC-1:0]    snk_ready
);

  localparam int VW   = vcl_idx_w(NVC);
  localparam int KEEP = vcl_keep_level(LF, LB);
  localparam int FW   = 1 + VW + DW;

  logic rst_meta_q, rst_sync_q, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i = rst_sync_q;

  logic [NVC-1:0] seen_rdy, rx_rdy, wr_en;
  logic           lnk_valid, fwd_valid;
  logic [VW-1:0]  lnk_vc, fwd_vc;
  logic [DW-1:0]  lnk_data, fwd_data;
  logic [FW-1:0]  fwd_in, fwd_out;

  vcl_sender #(.NVC(NVC), .DW(DW), .VW(VW)) u_sender (
    .clk      (clk),
    .rst_ni   (rst_i),
    .src_valid(src_valid),
    .src_data (src_data),
    .seen_rdy (seen_rdy),
    .src_ready(src_ready),
    .lnk_valid(lnk_valid),
    .lnk_vc   (lnk_vc),
    .lnk_data (lnk_data)
  );

  assign fwd_in = {lnk_valid, lnk_vc, lnk_data};

  vcl_delay #(.W(FW), .STAGES(LF)) u_fwd (
    .clk   (clk),
    .rst_ni(rst_i),
    .din   (fwd_in),
    .dout  (fwd_out)
  );

  assign {fwd_valid, fwd_vc, fwd_data} = fwd_out;

  vcl_delay #(.W(NVC), .STAGES(LB)) u_bwd (
    .clk   (clk),
    .rst_ni(rst_i),
    .din   (rx_rdy),
    .dout  (seen_rdy)
  );

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    assign wr_en[v] = fwd_valid && (fwd_vc == VW'(v));

    vcl_vc_fifo #(.DW(DW), .DEPTH(DEPTH), .KEEP(KEEP)) u_fifo (
      .clk      (clk),
      .rst_ni   (rst_i),
      .wr_en    (wr_en[v]),
      .wr_data  (fwd_data),
      .pop_valid(snk_valid[v]),
      .pop_data (snk_data[v*DW +: DW]),
      .pop_ready(snk_ready[v]),
      .rdy_out  (rx_rdy[v])
    );
  end

endmodule

// File: tb/vcl_pipe_link_bench.sv
module vcl_pipe_link_bench;

  localparam int NVC   = 3;
  localparam int DW    = 16;
  localparam int LF    = 3;
  localparam int LB    = 2;
  localparam int DEPTH = LF + LB + 2;

  typedef struct packed {
    logic [DW-1:0] d;
    logic [31:0]   c;
  } ent_t;

  logic              clk;
  logic              rst_n;
  logic [NVC-1:0]    src_valid;
  logic [NVC*DW-1:0] src_data;
  logic [NVC-1:0]    src_ready;
  logic [NVC-1:0]    snk_valid;
  logic [NVC*DW-1:0] snk_data;
  logic [NVC-1:0]    snk_ready;

  vcl_pipe_link #(.NVC(NVC), .DW(DW), .LF(LF), .LB(LB), .DEPTH(DEPTH)) u_vcl_pipe_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_valid(src_valid),
    .src_data (src_data),
    .src_ready(src_ready),
    .snk_valid(snk_valid),
    .snk_data (snk_data),
    .snk_ready(snk_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  ent_t exp_q [NVC][$];
  int   sent  [NVC];
  int   lim   [NVC];
  bit   src_on[NVC];
  int   snk_mode[NVC];   // 0 ready, 1 stalled, 2 random
  bit   src_rand = 0;
  bit   lat_mode = 0;
  int   lat_hits = 0;
  bit   rr_mode  = 0;
  int   rr_prev  = -1;
  bit   hold_pend[NVC];
  logic [DW-1:0] hold_d[NVC];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Driver: inputs change just after the rising edge.
  initial begin
    src_valid = '0;
    src_data  = '0;
    snk_ready = '0;
    for (int v = 0; v < NVC; v++) begin
      sent[v] = 0; lim[v] = 0; src_on[v] = 0; snk_mode[v] = 0; hold_pend[v] = 0;
    end
    forever begin
      @(posedge clk);
      #1;
      for (int v = 0; v < NVC; v++) begin
        src_valid[v] = src_on[v] && (sent[v] < lim[v]) &&
                       (!src_rand || ($urandom_range(0, 1) == 1));
        src_data[v*DW +: DW] = {4'(v), 12'(sent[v])};
        case (snk_mode[v])
          0: snk_ready[v] = 1'b1;
          1: snk_ready[v] = 1'b0;
          default: snk_ready[v] = ($urandom_range(0, 2) != 0);
        endcase
      end
    end
  end

  // Monitor: samples on the falling edge; scoreboard per channel.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        for (int v = 0; v < NVC; v++) begin
          if (src_valid[v] && src_ready[v]) begin
            ent_t e;
            e.d = src_data[v*DW +: DW];
            e.c = cyc;
            exp_q[v].push_back(e);
            sent[v]++;
            if (rr_mode) begin
              if (rr_prev >= 0)
                chk(v == (rr_prev + 1) % NVC, "R7 grant order", v, (rr_prev + 1) % NVC);
              rr_prev = v;
            end
          end
        end
        if ((src_ready & ~src_valid) != '0 || $countones(src_ready) > 1)
          chk(0, "R3 accept vector", src_ready, src_valid);
        for (int v = 0; v < NVC; v++) begin
          if (hold_pend[v]) begin
            chk(snk_valid[v] == 1'b1, "R9 valid held", snk_valid[v], 1);
            chk(snk_data[v*DW +: DW] == hold_d[v], "R9 data held", snk_data[v*DW +: DW], hold_d[v]);
          end
          hold_pend[v] = snk_valid[v] && !snk_ready[v];
          hold_d[v]    = snk_data[v*DW +: DW];
          if (snk_valid[v] && snk_ready[v]) begin
            if (exp_q[v].size() == 0) begin
              chk(0, "R2 unexpected flit", snk_data[v*DW +: DW], -1);
            end else begin
              ent_t e;
              e = exp_q[v].pop_front();
              chk(snk_data[v*DW +: DW] == e.d, "R2 data/order", snk_data[v*DW +: DW], e.d);
              if (lat_mode) begin
                lat_hits++;
                chk(cyc - int'(e.c) == LF + 1, "R6 idle latency", cyc - int'(e.c), LF + 1);
              end
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    int base0;
    rst_n = 1'b0;
    wait_cyc(5);
    // R1: reset state
    chk(snk_valid == '0, "R1 snk_valid in reset", snk_valid, 0);
    chk(src_ready == '0, "R1 src_ready in reset", src_ready, 0);
    #1 rst_n = 1'b1;
    wait_cyc(1);
    chk(src_ready == '0 && snk_valid == '0, "R1 after release", {src_ready, snk_valid}, 0);
    wait_cyc(10);

    // R6: single flit on an idle link
    lat_mode = 1;
    lim[0] = sent[0] + 1; src_on[0] = 1;
    wait_cyc(20);
    lat_mode = 0; src_on[0] = 0;
    chk(lat_hits == 1, "R6 flit delivered", lat_hits, 1);

    // R8: full rate on one channel
    lim[1] = 1000; src_on[1] = 1;
    wait_cyc(20);
    base = sent[1];
    wait_cyc(40);
    chk(sent[1] - base == 40, "R8 accepts in 40 cycles", sent[1] - base, 40);
    src_on[1] = 0;
    wait_cyc(20);

    // R4: exact fill of a stalled channel, then full delivery
    snk_mode[2] = 1;
    base = sent[2];
    lim[2] = base + 1000; src_on[2] = 1;
    wait_cyc(60);
    chk(sent[2] - base == DEPTH, "R4 stalled fill count", sent[2] - base, DEPTH);
    chk(snk_valid[2] == 1'b1, "R4 head waiting", snk_valid[2], 1);
    src_on[2] = 0;
    snk_mode[2] = 0;
    wait_cyc(30);
    chk(exp_q[2].size() == 0, "R4 all delivered after release", exp_q[2].size(), 0);

    // R7: rotation with all channels busy
    for (int v = 0; v < NVC; v++) begin
      lim[v] = sent[v] + 1000; src_on[v] = 1;
    end
    wait_cyc(10);
    rr_prev = -1; rr_mode = 1;
    wait_cyc(30);
    rr_mode = 0;
    for (int v = 0; v < NVC; v++) src_on[v] = 0;
    wait_cyc(20);

    // R5: channel 1 keeps flowing while channel 0 is blocked
    snk_mode[0] = 1;
    base0 = sent[0];
    src_on[0] = 1; src_on[1] = 1;
    wait_cyc(40);
    base = sent[1];
    wait_cyc(40);
    chk(sent[1] - base == 40, "R5 neighbour rate", sent[1] - base, 40);
    chk(sent[0] - base0 <= DEPTH, "R5 blocked channel bounded", sent[0] - base0, DEPTH);
    src_on[0] = 0; src_on[1] = 0;
    snk_mode[0] = 0;
    wait_cyc(40);

    // R2: random stalls on every sink and source
    src_rand = 1;
    for (int v = 0; v < NVC; v++) begin
      lim[v] = sent[v] + 100000; src_on[v] = 1; snk_mode[v] = 2;
    end
    wait_cyc(3000);
    for (int v = 0; v < NVC; v++) src_on[v] = 0;
    wait_cyc(5);
    for (int v = 0; v < NVC; v++) snk_mode[v] = 0;
    wait_cyc(60);
    for (int v = 0; v < NVC; v++)
      chk(exp_q[v].size() == 0, "R2 nothing lost after random run", exp_q[v].size(), 0);
    chk(snk_valid == '0, "R2 no extra flits", snk_valid, 0);

    summary();
    $finish;
  end

endmodule